// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns sampled D+ and D- line levels into the bytes of a low-speed USB packet. It runs on a system clock that is a fixed integer multiple of the bit rate, with `OVS` clocks per bit. The two line inputs pass through a two-flop synchroniser. The receiver then hunts for a J-to-K transition inside the sync pattern and re-locks its phase on every such transition. It declares sync only when the bit centre after a K is again a K. From then on it samples once per bit, at the centre.

Each sampled bit is NRZI-decoded and packed LSB first. The first byte is the PID and is placed on `pid`. Every byte, the PID included, appears on `data_byte` with a one-cycle `byte_valid` strobe. In the data bytes, stuffed bits are removed. SE0 closes the packet with a `pkt_end` pulse. A broken stuff rule or too many data bytes raises an error pulse. After an error the receiver stays deaf until the line shows SE0 and then J.

The controller has six states:
- `ST_HUNT` waits for a J-to-K edge.
- `ST_SYNC` times out to the centre of the next bit and checks for the second K.
- `ST_PID` collects the PID with no unstuffing.
- `ST_DATA` collects data bytes and drops stuff bits.
- `ST_DRAIN` swallows line activity after an error until SE0.
- `ST_WAIT_J` waits for J idle.

The transitions are:
- `ST_HUNT`→`ST_SYNC` on a J-to-K edge.
- `ST_SYNC`→`ST_SYNC` on a further J-to-K edge, which re-locks the phase.
- `ST_SYNC`→`ST_PID` when K is seen at the check point.
- `ST_SYNC`→`ST_HUNT` when J or SE0 is seen there instead.
- `ST_PID`→`ST_DATA` when the eighth bit arrives.
- `ST_PID`/`ST_DATA`→`ST_WAIT_J` on SE0 at a bit centre.
- `ST_PID`/`ST_DATA`→`ST_DRAIN` on a stuff error or an overflow.
- `ST_DRAIN`→`ST_WAIT_J` on SE0.
- `ST_WAIT_J`→`ST_HUNT` on J.

Top module: `usbls_rx`

## Requirements
- R1: While reset is held and immediately after it, `byte_valid`, `pkt_end`, `err_stuff` and `err_overflow` are 0 and `pid` is 0x00.
- R2: The line is decoded as follows: J is D+=0 and D-=1, K is D+=1 and D-=0, SE0 is both low, and both high counts as J. An unchanged line state between bit centres decodes to 1 and a change decodes to 0. Bits fill each byte from bit 0 upward, so data bytes appear on `data_byte` with the values sent.
- R3: Sync is accepted only after a J-to-K edge followed by K at the next bit centre. A sync pattern whose last bit is J instead of K produces no strobe of any kind, and the next well-formed packet is received.
- R4: The first byte after sync is placed on `pid` and strobed once on `byte_valid` (with the same value on `data_byte`). `pid` changes only together with `byte_valid`.
- R5: Inside the PID no bit is removed. A run of six 1 bits that reaches into the PID raises `err_stuff` and produces no `byte_valid`. The final K of sync counts as the first 1 of that run.
- R6: In data bytes, the bit that follows six consecutive 1s is discarded when it is a 0. The run counts across byte boundaries and from the PID into the data.
- R7: A bit following six consecutive 1s in the data that is itself a 1 raises `err_stuff`, and no further byte of that packet is strobed.
- R8: SE0 at a bit centre ends the packet with one `pkt_end` pulse. Bits of an incomplete byte are discarded.
- R9: When SE0 arrives in the slot where a stuff bit is expected, the last byte has already been strobed, `pkt_end` pulses and no error is flagged.
- R10: At most `BUF_BYTES` data bytes after the PID are strobed. Completing one more raises `err_overflow` instead of `byte_valid`.
- R11: After `err_stuff` or `err_overflow`, no `byte_valid` or `pkt_end` occurs until the line has shown SE0. After SE0 and then J idle, the next packet is received normally.
- R12: `byte_valid`, `pkt_end`, `err_stuff` and `err_overflow` are single-cycle pulses, at most one is high in a cycle, and two `byte_valid` pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `OVS` cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line level, asynchronous |
| usb_dm | input | 1 | D- line level, asynchronous |
| pid | output | 8 | PID of the most recent packet |
| data_byte | output | 8 | Received byte, valid with `byte_valid` |
| byte_valid | output | 1 | One-cycle strobe per received byte (PID included) |
| pkt_end | output | 1 | One-cycle pulse on SE0 ending a packet |
| err_stuff | output | 1 | One-cycle pulse on a stuff-rule violation |
| err_overflow | output | 1 | One-cycle pulse when the data byte budget is exceeded |

## Verification
A phase counter that drifts or a sync check made at the wrong point shows within one packet. Every byte value then comes out shifted or corrupted, and the data sweep compares all 256 byte values. A stuff-run counter that is off by one either drops a real data bit or lets a stuff bit through, which corrupts the byte carrying it. It can also raise or miss `err_stuff` at the sixth 1. A state that fails to leave `ST_DRAIN` or `ST_WAIT_J` shows as a missing next packet, and one that leaves too early shows as strobes during the errored packet.

// File: rtl/usbls_pkg.sv
package usbls_pkg;

    // Line state encoded as {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC,
        ST_PID,
        ST_DATA,
        ST_DRAIN,
        ST_WAIT_J
    } rx_state_e;

    // Ones run length after which a stuff bit follows
    localparam logic [2:0] STUFF_RUN = 3'd6;
    localparam logic [2:0] STUFF_PRE = 3'd5;

endpackage

// File: rtl/usbls_line_sync.sv
module usbls_line_sync
    import usbls_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  usb_dp,
    input  logic  usb_dm,
    output line_e line_now,
    output line_e line_prev
);

    logic [1:0] stage1_q;
    logic [1:0] stage2_q;
    logic [1:0] mapped;
    line_e      prev_q;

    // Both-high is folded onto J
    assign mapped    = (stage2_q == 2'b11) ? 2'b01 : stage2_q;
    assign line_now  = line_e'(mapped);
    assign line_prev = prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 2'b01;
            stage2_q <= 2'b01;
            prev_q   <= LN_J;
        end else begin
            stage1_q <= {usb_dp, usb_dm};
            stage2_q <= stage1_q;
            prev_q   <= line_e'(mapped);
        end
    end

endmodule

// File: rtl/usbls_bit_timer.sv
module usbls_bit_timer #(
    parameter int OVS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic at_bit,
    output logic at_sync
);

    // Sync check falls one and a half bits after the J-to-K edge
    localparam int SYNC_PT = OVS + OVS / 2 - 1;
    localparam int CW      = $clog2(SYNC_PT + 1);

    logic [CW-1:0] cnt_q;

    assign at_bit  = (cnt_q == CW'(OVS - 1));
    assign at_sync = (cnt_q == CW'(SYNC_PT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || at_sync) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/usbls_rx_fsm.sv
module usbls_rx_fsm
    import usbls_pkg::*;
#(
    parameter int BUF_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  line_e      line_now,
    input  line_e      line_prev,
    input  logic       at_bit,
    input  logic       at_sync,
    output logic       tmr_clr,
    output logic [7:0] pid,
    output logic [7:0] data_byte,
    output logic       byte_valid,
    output logic       pkt_end,
    output logic       err_stuff,
    output logic       err_overflow
);

    localparam int RW = $clog2(BUF_BYTES + 1);

    rx_state_e     state_q, state_d;
    line_e         bit_ref_q;
    logic [7:0]    shreg_q;
    logic [2:0]    bit_idx_q;
    logic [2:0]    ones_q;
    logic [RW-1:0] room_q;

    logic       edge_jk;
    logic       sample;
    logic       is_se0;
    logic       nrzi_one;
    logic       stuff_slot;
    logic       byte_done;
    logic [7:0] next_byte;

    assign edge_jk    = (line_prev == LN_J) && (line_now == LN_K);
    assign sample     = at_bit && ((state_q == ST_PID) || (state_q == ST_DATA));
    assign is_se0     = (line_now == LN_SE0);
    assign nrzi_one   = (line_now == bit_ref_q);
    assign stuff_slot = (state_q == ST_DATA) && (ones_q == STUFF_RUN);
    assign byte_done  = (bit_idx_q == 3'd7);
    assign next_byte  = {nrzi_one, shreg_q[7:1]};

    assign tmr_clr = sample
                   || ((state_q == ST_HUNT) && edge_jk)
                   || ((state_q == ST_SYNC) && (edge_jk || at_sync));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (edge_jk) state_d = ST_SYNC;
            end
            ST_SYNC: begin
                if (is_se0)       state_d = ST_HUNT;
                else if (edge_jk) state_d = ST_SYNC;
                else if (at_sync) state_d = (line_now == LN_K) ? ST_PID : ST_HUNT;
            end
            ST_PID: begin
                if (sample) begin
                    if (is_se0)                              state_d = ST_WAIT_J;
                    else if (nrzi_one && ones_q == STUFF_PRE) state_d = ST_DRAIN;
                    else if (byte_done)                       state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (sample) begin
                    if (is_se0)                          state_d = ST_WAIT_J;
                    else if (stuff_slot)                 state_d = nrzi_one ? ST_DRAIN : ST_DATA;
                    else if (byte_done && room_q == '0)  state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (is_se0) state_d = ST_WAIT_J;
            end
            ST_WAIT_J: begin
                if (line_now == LN_J) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_ref_q    <= LN_J;
            shreg_q      <= '0;
            bit_idx_q    <= '0;
            ones_q       <= '0;
            room_q       <= '0;
            pid          <= '0;
            data_byte    <= '0;
            byte_valid   <= 1'b0;
            pkt_end      <= 1'b0;
            err_stuff    <= 1'b0;
            err_overflow <= 1'b0;
        end else begin
            byte_valid   <= 1'b0;
            pkt_end      <= 1'b0;
            err_stuff    <= 1'b0;
            err_overflow <= 1'b0;
            unique case (state_q)
                ST_SYNC: begin
                    if (at_sync && !is_se0 && !edge_jk && line_now == LN_K) begin
                        bit_ref_q <= LN_K;
                        ones_q    <= 3'd1;   // trailing K-K of sync is a 1
                        bit_idx_q <= '0;
                    end
                end
                ST_PID: begin
                    if (sample) begin
                        if (is_se0) begin
                            pkt_end <= 1'b1;
                        end else if (nrzi_one && ones_q == STUFF_PRE) begin
                            err_stuff <= 1'b1;
                        end else begin
                            bit_ref_q <= line_now;
                            shreg_q   <= next_byte;
                            ones_q    <= nrzi_one ? ones_q + 1'b1 : 3'd0;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            if (byte_done) begin
                                pid        <= next_byte;
                                data_byte  <= next_byte;
                                byte_valid <= 1'b1;
                                room_q     <= RW'(BUF_BYTES);
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (sample) begin
                        if (is_se0) begin
                            pkt_end <= 1'b1;
                        end else if (stuff_slot) begin
                            if (nrzi_one) begin
                                err_stuff <= 1'b1;
                            end else begin
                                bit_ref_q <= line_now;
                                ones_q    <= 3'd0;
                            end
                        end else begin
                            bit_ref_q <= line_now;
                            shreg_q   <= next_byte;
                            ones_q    <= nrzi_one ? ones_q + 1'b1 : 3'd0;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            if (byte_done) begin
                                if (room_q == '0) begin
                                    err_overflow <= 1'b1;
                                end else begin
                                    data_byte  <= next_byte;
                                    byte_valid <= 1'b1;
                                    room_q     <= room_q - 1'b1;
                                end
                            end
                        end
                    end
                end
                ST_HUNT, ST_DRAIN, ST_WAIT_J: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
    import usbls_pkg::*;
#(
    parameter int OVS       = 12,
    parameter int BUF_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usb_dp,
    input  logic       usb_dm,
    output logic [7:0] pid,
    output logic [7:0] data_byte,
    output logic       byte_valid,
    output logic       pkt_end,
    output logic       err_stuff,
    output logic       err_overflow
);

    line_e line_now;
    line_e line_prev;
    logic  at_bit;
    logic  at_sync;
    logic  tmr_clr;

    usbls_line_sync i_line_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .usb_dp    (usb_dp),
        .usb_dm    (usb_dm),
        .line_now  (line_now),
        .line_prev (line_prev)
    );

    usbls_bit_timer #(.OVS(OVS)) i_bit_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .at_bit  (at_bit),
        .at_sync (at_sync)
    );

    usbls_rx_fsm #(.BUF_BYTES(BUF_BYTES)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_now     (line_now),
        .line_prev    (line_prev),
        .at_bit       (at_bit),
        .at_sync      (at_sync),
        .tmr_clr      (tmr_clr),
        .pid          (pid),
        .data_byte    (data_byte),
        .byte_valid   (byte_valid),
        .pkt_end      (pkt_end),
        .err_stuff    (err_stuff),
        .err_overflow (err_overflow)
    );

endmodule

// File: rtl/usbls_rx_chk.sv
module usbls_rx_chk #(
    parameter int BUF_BYTES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       usb_dp,
    input logic       usb_dm,
    input logic [7:0] pid,
    input logic       byte_valid,
    input logic       pkt_end,
    input logic       err_stuff,
    input logic       err_overflow
);

    localparam int NW = $clog2(BUF_BYTES + 2) + 1;

    logic          quiet_q;
    logic [NW-1:0] nbytes_q;

    // Set by an error, cleared once the raw line shows SE0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      quiet_q <= 1'b0;
        else if (err_stuff || err_overflow) quiet_q <= 1'b1;
        else if (!usb_dp && !usb_dm)     quiet_q <= 1'b0;
    end

    // Bytes strobed in the current packet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   nbytes_q <= '0;
        else if (pkt_end || err_stuff || err_overflow) nbytes_q <= '0;
        else if (byte_valid)                          nbytes_q <= nbytes_q + 1'b1;
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid, pkt_end, err_stuff, err_overflow})); // R12
    AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R12
    AST_PID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pid) |-> byte_valid); // R4
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q |-> (!byte_valid && !pkt_end)); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (nbytes_q <= NW'(BUF_BYTES))); // R10

endmodule

bind usbls_rx usbls_rx_chk #(.BUF_BYTES(BUF_BYTES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .usb_dp       (usb_dp),
    .usb_dm       (usb_dm),
    .pid          (pid),
    .byte_valid   (byte_valid),
    .pkt_end      (pkt_end),
    .err_stuff    (err_stuff),
    .err_overflow (err_overflow)
);

// File: tb/test_usbls_rx.sv
module test_usbls_rx;

    localparam int OVS = 12;
    localparam int BUF = 8;
    localparam logic [1:0] LJ   = 2'b01;
    localparam logic [1:0] LK   = 2'b10;
    localparam logic [1:0] LSE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0;
    logic       dm = 1'b1;
    logic [7:0] pid;
    logic [7:0] data_byte;
    logic       byte_valid;
    logic       pkt_end;
    logic       err_stuff;
    logic       err_overflow;

    always #5 clk = ~clk;

    usbls_rx #(.OVS(OVS), .BUF_BYTES(BUF)) i_usbls_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .usb_dp       (dp),
        .usb_dm       (dm),
        .pid          (pid),
        .data_byte    (data_byte),
        .byte_valid   (byte_valid),
        .pkt_end      (pkt_end),
        .err_stuff    (err_stuff),
        .err_overflow (err_overflow)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] got [0:31];
    int n_got = 0;
    int n_end = 0;
    int n_est = 0;
    int n_eov = 0;
    int n_multi = 0;
    logic [1:0] cur_ln = 2'b01;
    int tx_ones = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (n_got < 32) got[n_got] = data_byte;
                n_got++;
            end
            if (pkt_end)      n_end++;
            if (err_stuff)    n_est++;
            if (err_overflow) n_eov++;
            if (int'(byte_valid) + int'(pkt_end) + int'(err_stuff) + int'(err_overflow) > 1)
                n_multi++;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] st);
        {dp, dm} = st;
        repeat (OVS) @(negedge clk);
    endtask

    task automatic tx_bit(input bit b);
        if (!b) cur_ln = (cur_ln == LJ) ? LK : LJ;
        put(cur_ln);
        tx_ones = b ? tx_ones + 1 : 0;
    endtask

    task automatic tx_sync();
        cur_ln  = LJ;
        tx_ones = 0;
        for (int i = 0; i < 7; i++) tx_bit(1'b0);
        tx_bit(1'b1);
    endtask

    task automatic tx_byte(input logic [7:0] v, input bit stuff, input bit last_nostuff);
        for (int i = 0; i < 8; i++) begin
            tx_bit(v[i]);
            if (stuff && tx_ones == 6 && !(last_nostuff && i == 7)) tx_bit(1'b0);
        end
    endtask

    task automatic tx_eop();
        put(LSE0);
        put(LSE0);
        cur_ln = LJ;
        put(LJ);
        put(LJ);
    endtask

    task automatic idle(input int n);
        cur_ln = LJ;
        repeat (n) put(LJ);
    endtask

    task automatic clear_mon();
        n_got = 0; n_end = 0; n_est = 0; n_eov = 0;
    endtask

    // Good packet after an abnormal one: proves rearm (R11)
    task automatic good_after(input string tag);
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'h69, 1'b0, 1'b0);
        tx_byte(8'h5A, 1'b1, 1'b0);
        tx_eop();
        idle(2);
        chk({tag, " R11 bytes"}, n_got, 2);
        chk({tag, " R11 data"}, int'(got[1]), 32'h5A);
        chk({tag, " R11 end"}, n_end, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog R12 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 pkt_end", int'(pkt_end), 0);
        chk("R1 errors", int'(err_stuff) + int'(err_overflow), 0);
        chk("R1 pid", int'(pid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(byte_valid) + int'(pkt_end), 0);
        idle(3);

        // R4 / R2: sweep of all 16 well-formed PIDs
        for (int p = 0; p < 16; p++) begin
            logic [7:0] pv;
            logic [7:0] dv;
            pv = {~p[3:0], p[3:0]};
            dv = 8'(p * 17 + 3);
            clear_mon();
            idle(2);
            tx_sync();
            tx_byte(pv, 1'b0, 1'b0);
            tx_byte(dv, 1'b1, 1'b0);
            tx_eop();
            idle(1);
            chk("R4 byte count", n_got, 2);
            chk("R4 pid output", int'(pid), int'(pv));
            chk("R4 first byte", int'(got[0]), int'(pv));
            chk("R2 data byte", int'(got[1]), int'(dv));
            chk("R8 single end", n_end, 1);
            chk("R5 no error", n_est + n_eov, 0);
        end

        // R2 / R6: every byte value, stuffing inserted by the sender
        for (int pk = 0; pk < 32; pk++) begin
            clear_mon();
            idle(2);
            tx_sync();
            tx_byte(8'hC3, 1'b0, 1'b0);
            for (int k = 0; k < 8; k++) tx_byte(8'(pk * 8 + k), 1'b1, 1'b0);
            tx_eop();
            idle(1);
            chk("R6 byte count", n_got, 9);
            for (int k = 0; k < 8; k++)
                chk("R2 R6 byte value", int'(got[k + 1]), pk * 8 + k);
            chk("R6 no stuff error", n_est, 0);
        end

        // R3: sync whose last bit is J
        clear_mon();
        idle(2);
        cur_ln = LJ;
        for (int i = 0; i < 8; i++) tx_bit(1'b0);
        idle(4);
        chk("R3 no strobes", n_got + n_end + n_est + n_eov, 0);
        good_after("R3");

        // R5: six ones reaching into the PID
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'h1F, 1'b0, 1'b0);
        tx_byte(8'h00, 1'b0, 1'b0);
        tx_eop();
        idle(1);
        chk("R5 stuff error", n_est, 1);
        chk("R5 no byte", n_got, 0);
        good_after("R5");

        // R7: non-transition stuff bit, then R11: sync+PID ignored before SE0
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'hC3, 1'b0, 1'b0);
        tx_byte(8'h7F, 1'b0, 1'b0);
        tx_byte(8'h12, 1'b1, 1'b0);
        tx_sync();
        tx_byte(8'hC3, 1'b0, 1'b0);
        tx_byte(8'h11, 1'b1, 1'b0);
        tx_eop();
        idle(1);
        chk("R7 stuff error", n_est, 1);
        chk("R7 only pid", n_got, 1);
        chk("R11 no end", n_end, 0);
        good_after("R7");

        // R8: partial byte before SE0
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'hD2, 1'b0, 1'b0);
        tx_byte(8'hA5, 1'b1, 1'b0);
        tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
        tx_eop();
        idle(1);
        chk("R8 bytes", n_got, 2);
        chk("R8 value", int'(got[1]), 32'hA5);
        chk("R8 end", n_end, 1);
        chk("R8 no error", n_est + n_eov, 0);

        // R9: SE0 in the stuff slot
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'hC3, 1'b0, 1'b0);
        tx_byte(8'hFC, 1'b1, 1'b1);
        tx_eop();
        idle(1);
        chk("R9 bytes", n_got, 2);
        chk("R9 value", int'(got[1]), 32'hFC);
        chk("R9 end", n_end, 1);
        chk("R9 no error", n_est, 0);

        // R10: one byte beyond the budget
        clear_mon();
        idle(2);
        tx_sync();
        tx_byte(8'hC3, 1'b0, 1'b0);
        for (int k = 0; k < BUF + 1; k++) tx_byte(8'(16 + k), 1'b1, 1'b0);
        tx_eop();
        idle(1);
        chk("R10 bytes", n_got, BUF + 1);
        chk("R10 last kept", int'(got[BUF]), 16 + BUF - 1);
        chk("R10 overflow", n_eov, 1);
        chk("R11 no end after error", n_end, 0);
        good_after("R10");

        chk("R12 one pulse per cycle", n_multi, 0);
        finish_run();
    end

endmodule